// File: doc/BRIEF.md
# Vertical-blank change interrupt generator

This block raises an interrupt to the host processor each time the vertical-blanking level from the display timing changes state, on entry into blanking and on exit from it alike. Each change produces one pulse of fixed length, about 250 ns, so that a slow host cannot miss it. The host keeps its own copy of the blanking state and flips it once per interrupt. For that copy to stay correct, the generator must not fire before the host has set up its flag.

The generator therefore starts out disabled after power-on reset. It stays disabled until the port decoder sends an enable strobe, which comes from the host's dedicated "release" port command. Once set, the enable holds until the next reset. Blanking changes that happen while the block is disabled are dropped, not stored. The blank level is asynchronous to the block clock and passes through a two-stage synchronizer before edges are detected. All pins are plain level or strobe controls. There is no streaming interface, so no valid/ready handshake applies.

Top module: `vblank_irq_gen`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `irq_o` is 0 and the block is disabled.
- R2: While disabled, no change of `vblank_i` in either direction makes `irq_o` go high.
- R3: A one-cycle high on `arm_i` enables the block from the next clock edge on. It stays enabled without further strobes, and a repeated strobe changes nothing.
- R4: When enabled, a 0-to-1 change of `vblank_i` (set up before clock edge 1) drives `irq_o` high after clock edge 3: two edges for synchronizing and one for loading the pulse counter.
- R5: When enabled, a 1-to-0 change of `vblank_i` produces the same pulse with the same latency as in R4.
- R6: Each pulse lasts exactly ceil(PULSE_NS*CLK_MHZ/1000) clock cycles. This is 63 cycles with the defaults PULSE_NS=250 and CLK_MHZ=250.
- R7: A change that is detected while a pulse is still running restarts the count. `irq_o` then stays high without a gap until the full R6 length after the later change has elapsed.
- R8: A change that occurs while disabled is discarded. Enabling the block afterwards, with `vblank_i` held steady, produces no pulse.
- R9: A reset clears the enable. After it, changes of `vblank_i` are silent again until a new `arm_i` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| vblank_i | input | 1 | Vertical-blank level from display timing, asynchronous |
| arm_i | input | 1 | Enable strobe decoded from the host port command |
| irq_o | output | 1 | Active-high interrupt pulse to the host |

## Verification
The assertions assume that `arm_i` is a clean synchronous strobe. They also assume that `vblank_i` is a level whose changes are at least one clock apart. Otherwise the synchronized copy could hide a change and the latency and width properties would not describe what the host sees. The bench drives every input at the falling clock edge and holds each blank level for many cycles. The only exception is the restart case, where the second change is placed on purpose while the first pulse is still running.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

  // Pair of one-cycle edge flags for the synchronized blank level.
  typedef struct packed {
    logic rise;
    logic fall;
  } blank_edge_t;

  // Pulse length in clock cycles, rounded up, never below one.
  function automatic int ns_to_cycles(input int ns, input int clk_mhz);
    int c;
    c = (ns * clk_mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/vbi_sync.sv
module vbi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vbi_edge_detect.sv
module vbi_edge_detect
  import vbi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        level_i,
  output blank_edge_t edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign edge_o.rise = level_i & ~prev_q;
  assign edge_o.fall = ~level_i & prev_q;

  // R4
  rise_tracks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o.rise |=> prev_q);
  // R5
  fall_tracks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o.fall |=> !prev_q);
endmodule

// File: rtl/vbi_arm.sv
module vbi_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic armed_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_o <= 1'b0;
    else if (arm_i) armed_o <= 1'b1;
  end

  // R3
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> armed_o);
  // R3
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> armed_o);
endmodule

// File: rtl/vbi_pulse_stretch.sv
module vbi_pulse_stretch #(
  parameter int PULSE_CYC = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (trig_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_o = (cnt_q != '0);

  // R7
  trig_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pulse_o);
  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && pulse_o) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R6
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !pulse_o) |=> !pulse_o);
endmodule

// File: rtl/vblank_irq_gen.sv
module vblank_irq_gen
  import vbi_pkg::*;
#(
  parameter int PULSE_NS    = 250,
  parameter int CLK_MHZ     = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_i,
  input  logic arm_i,
  output logic irq_o
);
  localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_MHZ);

  logic        blank_s;
  blank_edge_t blank_edge;
  logic        armed;
  logic        fire;

  vbi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (vblank_i),
    .q_o   (blank_s)
  );

  vbi_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (blank_s),
    .edge_o  (blank_edge)
  );

  vbi_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm_i),
    .armed_o (armed)
  );

  // Edges seen while disabled are simply not forwarded: nothing is queued.
  assign fire = armed & (blank_edge.rise | blank_edge.fall);

  vbi_pulse_stretch #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (fire),
    .pulse_o (irq_o)
  );

  // R2
  silent_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !irq_o) |=> !irq_o);
  // R4
  rise_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(blank_s) && armed) |=> irq_o);
  // R5
  fall_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blank_s) && armed) |=> irq_o);
endmodule

// File: tb/vblank_irq_gen_tb.sv
module vblank_irq_gen_tb;
  localparam int W   = 63;       // ceil(250*250/1000)
  localparam int WIN = W + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vblank_i = 1'b0;
  logic arm_i = 1'b0;
  logic irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vblank_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i), .arm_i(arm_i), .irq_o(irq_o)
  );

  // {arm strobe before change, new blank level, pulse expected}
  localparam logic [2:0] VEC [6] = '{
    3'b0_1_0,  // R2 rise while disabled
    3'b0_0_0,  // R2 fall while disabled
    3'b1_1_1,  // R4 rise after enable
    3'b0_0_1,  // R5 fall
    3'b1_1_1,  // R3 repeated strobe harmless
    3'b0_0_1   // R6 width again on fall
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", int'(irq_o), 0);
  endtask

  task automatic strobe_arm();
    @(negedge clk);
    arm_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  // Samples irq_o at n falling edges; first = index of first high (-1 if none).
  task automatic watch(input int n, output int first, output int cnt);
    first = -1;
    cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (irq_o) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
  endtask

  initial begin
    int first, cnt, last;
    do_reset();
    repeat (5) @(negedge clk);

    // Vector table walk.
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][2]) strobe_arm();
      vblank_i = VEC[v][1];
      watch(WIN, first, cnt);
      if (VEC[v][0]) begin
        chk($sformatf("R4/R5 latency vec%0d", v), first, 3);
        chk($sformatf("R6 width vec%0d", v), cnt, W);
      end else begin
        chk($sformatf("R2 silent vec%0d first", v), first, -1);
        chk($sformatf("R2 silent vec%0d count", v), cnt, 0);
      end
    end

    // R7: second change while pulse active restarts the count.
    vblank_i = ~vblank_i;
    first = -1; cnt = 0; last = -1;
    for (int i = 1; i <= 10 + W + 12; i++) begin
      @(negedge clk);
      if (irq_o) begin
        cnt++; last = i;
        if (first < 0) first = i;
      end
      if (i == 10) vblank_i = ~vblank_i;
    end
    chk("R7 first high", first, 3);
    chk("R7 last high", last, 12 + W);
    chk("R7 no gap", cnt, W + 10);

    // R9: reset clears enable.
    do_reset();
    repeat (4) @(negedge clk);
    vblank_i = ~vblank_i;
    watch(WIN, first, cnt);
    chk("R9 silent after reset", cnt, 0);

    // R8: change while disabled, then enable: nothing queued.
    vblank_i = ~vblank_i;
    repeat (6) @(negedge clk);
    strobe_arm();
    watch(WIN, first, cnt);
    chk("R8 no queued pulse", cnt, 0);
    // R3: enabled now, a fresh change fires.
    vblank_i = ~vblank_i;
    watch(WIN, first, cnt);
    chk("R3 enabled fires", first, 3);
    chk("R6 width after R8", cnt, W);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule